// File: doc/BRIEF.md
# Interrupt Aggregator with Holdoff Timer

This block gathers up to 26 single-cycle event inputs into a sticky status word, masks that word bit by bit, and drives one interrupt line toward the host. Host software reaches four word-wide registers over a simple single-cycle read/write bus: the status word, the mask, a global enable, and a holdoff setting. Status bits are cleared as a side effect of reading the status word. Writing to the status word does nothing.

After every status read, a countdown is reloaded from the holdoff setting. The interrupt line stays low until that countdown reaches zero. The countdown advances once per pulse on a 100 µs tick input. A mode bit picks when the countdown starts. With the mode bit at 0, it starts right after the reload, as long as the enable is set. With the mode bit at 1, it waits for a new event that arrives while the enable is set. This limits how often the host can be interrupted.

Top module: `irq_hold_top`

## Requirements
- R1: A 1 on event input bit n (n in 25..20, 16, 14..0) sets status bit n on the next clock edge, whatever the mask holds. A status bit stays set until the status word is read.
- R2: A read of address 0 (status) returns the status word and clears every status bit at that clock edge. An event that arrives in the same cycle as the read is still set afterwards.
- R3: A write to address 0 leaves the status word unchanged.
- R4: Status bit 15 reads as the OR of status bits 25..16. Status bits 31..26 and 19..17 always read 0. Event inputs 15, 17, 18 and 19 are ignored.
- R5: After reset, the status word reads 32'h03008000, so bits 25 and 24 are pending. The mask, enable and holdoff registers all read 0.
- R6: irqOut is 1 exactly when all of the following hold: some status bit and its mask bit are both 1, enable bit 0 is 1, and the holdoff countdown is at zero.
- R7: The enable register (address 2, bit 0) never changes status or mask contents. While the enable is 0, the holdoff countdown neither starts nor advances.
- R8: A status read loads the countdown from holdoff bits 7..0. Once running, the countdown drops by one on each clock edge where tickIn is 1, and it stops at zero.
- R9: With holdoff bit 8 at 0, the countdown starts at the first clock edge after the reload at which the enable is 1.
- R10: With holdoff bit 8 at 1, the countdown starts only at a clock edge where the enable is 1 and a non-ignored event input is 1.
- R11: A holdoff value of 0 adds no delay in either mode.
- R12: Register readback works as follows:
  - the mask (address 1) keeps bits 25..20 and 16..0;
  - the enable keeps bit 0;
  - the holdoff (address 3) keeps bits 8..0;
  - all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | 0 status, 1 mask, 2 enable, 3 holdoff |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| eventIn | input | 26 | Event pulses, one per status bit |
| tickIn | input | 1 | 100 µs time-base pulse |
| irqOut | output | 1 | Interrupt request |

## Verification
A status bit that is lost or stuck shows on the next status read, and also in irqOut during the same cycle once its mask and the enable are set. A countdown state that is wrong shows as irqOut rising too early or too late. When a holdoff starts at the wrong edge, the error is one tick period. When the countdown fails to freeze, the error grows with every tick while the enable is low. For this reason the bench compares irqOut with a model on every cycle, and the status word at every read.

// File: rtl/irq_hold_pkg.sv
package irq_hold_pkg;
  localparam int SRC_W   = 26;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int HOLD_W  = 8;
  localparam int SUM_BIT = 15;
  localparam int SUM_LO  = 16;
  localparam int HCFG_W  = HOLD_W + 1;

  localparam logic [SRC_W-1:0] EVT_IMPL   = 26'h3F1_7FFF;
  localparam logic [SRC_W-1:0] MASK_IMPL  = 26'h3F1_FFFF;
  localparam logic [SRC_W-1:0] STATUS_RST = 26'h300_0000;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_MASK   = 2'd1,
    ADDR_ENABLE = 2'd2,
    ADDR_HOLD   = 2'd3
  } regAddr_t;

  typedef enum logic [1:0] {
    HOLD_IDLE  = 2'd0,
    HOLD_ARMED = 2'd1,
    HOLD_RUN   = 2'd2
  } holdState_t;

  typedef struct packed {
    logic rdStatus;
    logic wrMask;
    logic wrEnable;
    logic wrHold;
    logic loadCnt;
    logic decCnt;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_hold_ctrl.sv
module irq_hold_ctrl
  import irq_hold_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  enableQ,
  input  logic                  holdMode,
  input  logic                  cntZero,
  input  logic                  anyEvent,
  input  logic                  tickIn,
  output ctrlStrobe_t           strobe
);
  holdState_t stateQ, stateD;
  logic rdStatus;

  assign rdStatus = busSel && !busWr && (busAddr == ADDR_STATUS);

  // Bus decode and counter strobes
  always_comb begin
    strobe          = '0;
    strobe.rdStatus = rdStatus;
    strobe.wrMask   = busSel && busWr && (busAddr == ADDR_MASK);
    strobe.wrEnable = busSel && busWr && (busAddr == ADDR_ENABLE);
    strobe.wrHold   = busSel && busWr && (busAddr == ADDR_HOLD);
    strobe.loadCnt  = rdStatus;
    strobe.decCnt   = (stateQ == HOLD_RUN) && enableQ && tickIn && !cntZero && !rdStatus;
  end

  // Holdoff start/run sequencing
  always_comb begin
    stateD = stateQ;
    if (rdStatus) begin
      stateD = HOLD_ARMED;
    end else begin
      unique case (stateQ)
        HOLD_ARMED: if (enableQ && (!holdMode || anyEvent)) stateD = HOLD_RUN;
        HOLD_RUN:   if (cntZero) stateD = HOLD_IDLE;
        default:    stateD = stateQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= HOLD_IDLE;
    else       stateQ <= stateD;
  end
endmodule

// File: rtl/irq_hold_dp.sv
module irq_hold_dp
  import irq_hold_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWrData,
  input  logic [SRC_W-1:0]      eventIn,
  output logic [DATA_W-1:0]     busRdData,
  output logic [DATA_W-1:0]     statusView,
  output logic [SRC_W-1:0]      maskQ,
  output logic                  enableQ,
  output logic [HCFG_W-1:0]     holdQ,
  output logic [HOLD_W-1:0]     holdCnt,
  output logic                  holdMode,
  output logic                  cntZero,
  output logic                  anyEvent,
  output logic                  irqOut
);
  logic [SRC_W-1:0] statusQ;
  logic [SRC_W-1:0] liveEvt;

  assign liveEvt  = eventIn & EVT_IMPL;
  assign anyEvent = |liveEvt;
  assign holdMode = holdQ[HOLD_W];
  assign cntZero  = (holdCnt == '0);

  always_comb begin
    statusView                 = '0;
    statusView[SRC_W-1:0]      = statusQ & EVT_IMPL;
    statusView[SUM_BIT]        = |statusQ[SRC_W-1:SUM_LO];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= STATUS_RST;
      maskQ   <= '0;
      enableQ <= 1'b0;
      holdQ   <= '0;
      holdCnt <= '0;
    end else begin
      statusQ <= (strobe.rdStatus ? '0 : statusQ) | liveEvt;
      if (strobe.wrMask)   maskQ   <= busWrData[SRC_W-1:0] & MASK_IMPL;
      if (strobe.wrEnable) enableQ <= busWrData[0];
      if (strobe.wrHold)   holdQ   <= busWrData[HCFG_W-1:0];
      if (strobe.loadCnt)     holdCnt <= holdQ[HOLD_W-1:0];
      else if (strobe.decCnt) holdCnt <= holdCnt - 1'b1;
    end
  end

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      ADDR_STATUS: busRdData = statusView;
      ADDR_MASK:   busRdData[SRC_W-1:0]  = maskQ;
      ADDR_ENABLE: busRdData[0]          = enableQ;
      default:     busRdData[HCFG_W-1:0] = holdQ;
    endcase
  end

  assign irqOut = (|(statusView[SRC_W-1:0] & maskQ)) && enableQ && cntZero;
endmodule

// File: rtl/irq_hold_top.sv
module irq_hold_top
  import irq_hold_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic [25:0]       eventIn,
  input  logic              tickIn,
  output logic              irqOut
);
  ctrlStrobe_t       strobe;
  logic [DATA_W-1:0] statusView;
  logic [SRC_W-1:0]  maskQ;
  logic              enableQ;
  logic [HCFG_W-1:0] holdQ;
  logic [HOLD_W-1:0] holdCnt;
  logic              holdMode, cntZero, anyEvent;

  irq_hold_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .enableQ(enableQ), .holdMode(holdMode), .cntZero(cntZero),
    .anyEvent(anyEvent), .tickIn(tickIn), .strobe(strobe)
  );

  irq_hold_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWrData(busWrData), .eventIn(eventIn), .busRdData(busRdData),
    .statusView(statusView), .maskQ(maskQ), .enableQ(enableQ), .holdQ(holdQ),
    .holdCnt(holdCnt), .holdMode(holdMode), .cntZero(cntZero),
    .anyEvent(anyEvent), .irqOut(irqOut)
  );
endmodule

// File: rtl/irq_hold_chk.sv
module irq_hold_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busSel,
  input logic        busWr,
  input logic [1:0]  busAddr,
  input logic [31:0] busRdData,
  input logic [25:0] eventIn,
  input logic [31:0] statusView,
  input logic        enableQ,
  input logic [8:0]  holdQ,
  input logic [7:0]  holdCnt,
  input logic        irqOut
);
  logic rdStatus;
  assign rdStatus = busSel && !busWr && (busAddr == 2'd0);

  // R6
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> enableQ);

  // R2
  event_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    eventIn[0] |=> statusView[0]);

  // R8
  hold_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && holdQ[7:0] != 8'd0) |=> !irqOut);

  // R11
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && holdQ[7:0] == 8'd0) |=> (holdCnt == 8'd0));

  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enableQ && !rdStatus) |=> $stable(holdCnt));

  // R4
  status_gaps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd0) |-> (busRdData[31:26] == 6'd0 && busRdData[19:17] == 3'd0));
endmodule

bind irq_hold_top irq_hold_chk u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busRdData(busRdData), .eventIn(eventIn), .statusView(statusView),
  .enableQ(enableQ), .holdQ(holdQ), .holdCnt(holdCnt), .irqOut(irqOut)
);

// File: tb/irq_hold_top_bench.sv
`timescale 1ns/1ps
module irq_hold_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0, tickIn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWrData = '0;
  logic [25:0] eventIn = '0;
  logic [31:0] busRdData;
  logic        irqOut;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  localparam logic [25:0] EVT_OK  = 26'h3F1_7FFF;
  localparam logic [25:0] MASK_OK = 26'h3F1_FFFF;

  // reference state
  logic [25:0] mStat, mMask;
  logic        mEn;
  logic [8:0]  mHold;
  logic [7:0]  mCnt;
  int          mState;

  irq_hold_top u_irq_hold_top (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .eventIn(eventIn),
    .tickIn(tickIn), .irqOut(irqOut)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] viewStatus(input logic [25:0] s);
    logic [31:0] v;
    v = {6'd0, s & EVT_OK};
    v[15] = |s[25:16];
    return v;
  endfunction

  function automatic logic [31:0] expRead(input logic [1:0] a);
    case (a)
      2'd0:    return viewStatus(mStat);
      2'd1:    return {6'd0, mMask};
      2'd2:    return {31'd0, mEn};
      default: return {23'd0, mHold};
    endcase
  endfunction

  function automatic logic expIrq();
    return (|(viewStatus(mStat)[25:0] & mMask)) && mEn && (mCnt == 8'd0);
  endfunction

  task automatic modelReset();
    mStat = 26'h300_0000; mMask = '0; mEn = 1'b0; mHold = '0; mCnt = '0; mState = 0;
  endtask

  task automatic modelEdge();
    logic rd, ev, dec;
    int   nState;
    rd  = busSel && !busWr && busAddr == 2'd0;
    ev  = |(eventIn & EVT_OK);
    dec = (mState == 2) && mEn && tickIn && (mCnt != 0) && !rd;
    nState = mState;
    if (rd) nState = 1;
    else if (mState == 1 && mEn && (!mHold[8] || ev)) nState = 2;
    else if (mState == 2 && mCnt == 0) nState = 0;
    if (rd) mCnt = mHold[7:0];
    else if (dec) mCnt = mCnt - 8'd1;
    mState = nState;
    mStat = (rd ? 26'd0 : mStat) | (eventIn & EVT_OK);
    if (busSel && busWr) begin
      if (busAddr == 2'd1) mMask = busWrData[25:0] & MASK_OK;
      if (busAddr == 2'd2) mEn = busWrData[0];
      if (busAddr == 2'd3) mHold = busWrData[8:0];
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check, then advance the model at posedge
  task automatic step(input logic sel, input logic wr, input logic [1:0] a,
                      input logic [31:0] wd, input logic [25:0] ev, input logic tk,
                      input string tag);
    @(negedge clk);
    busSel = sel; busWr = wr; busAddr = a; busWrData = wd; eventIn = ev; tickIn = tk;
    #1;
    if (sel && !wr) check({tag, " read"}, busRdData, expRead(a));
    check({tag, " irq"}, {31'd0, irqOut}, {31'd0, expIrq()});
    @(posedge clk);
    modelEdge();
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    step(1, 0, a, 0, 0, 0, tag);
  endtask
  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
    step(1, 1, a, d, 0, 0, tag);
  endtask
  task automatic idle(input logic [25:0] ev, input logic tk, input string tag);
    step(0, 0, 0, 0, ev, tk, tag);
  endtask

  task automatic peek(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busSel = 0; busWr = 0; busAddr = a; eventIn = 0; tickIn = 0;
    #1;
    check(tag, busRdData, exp);
    @(posedge clk);
    modelEdge();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R5 reset values
    peek(0, 32'h0300_8000, "R5 status");
    peek(1, 32'h0, "R5 mask");
    peek(2, 32'h0, "R5 enable");
    peek(3, 32'h0, "R5 holdoff");
    rd(0, "R5");
    peek(0, 32'h0, "R2 cleared");

    // R12 readback widths
    wr(1, 32'hFFFF_FFFF, "R12");
    peek(1, 32'h03F1_FFFF, "R12 mask");
    wr(2, 32'hFFFF_FFFF, "R12");
    peek(2, 32'h1, "R12 enable");
    wr(3, 32'hFFFF_FFFF, "R12");
    peek(3, 32'h1FF, "R12 holdoff");
    wr(3, 0, "R12"); wr(1, 0, "R12");

    // R1 latching regardless of mask
    idle(26'h3FF_FFFF, 0, "R1");
    idle(0, 0, "R1");
    peek(0, 32'h03F1_FFFF, "R1 all events");
    rd(0, "R1");

    // R3 writes ignored
    wr(0, 32'hFFFF_FFFF, "R3");
    peek(0, 32'h0, "R3 status after write");

    // R2 event during read survives
    step(1, 0, 0, 0, 26'h8, 0, "R2");
    peek(0, 32'h8, "R2 same-cycle event");
    rd(0, "R2");

    // R4 ignored inputs and summary
    idle(26'h00E_8000, 0, "R4");
    peek(0, 32'h0, "R4 ignored inputs");
    idle(26'h010_0000, 0, "R4");
    peek(0, 32'h0010_8000, "R4 summary bit");
    rd(0, "R4");

    // R6 gating, R7 enable leaves contents
    wr(1, 32'h1, "R6"); wr(2, 32'h0, "R6");
    idle(26'h1, 0, "R6");
    peek(0, 32'h1, "R7 status kept with enable low");
    wr(2, 32'h1, "R6");
    peek(1, 32'h1, "R7 mask kept");
    wr(1, 32'h8000, "R6");
    idle(0, 0, "R6 summary masked");
    idle(26'h0040_0000, 0, "R6");
    idle(0, 0, "R6");
    wr(1, 32'h1, "R6");

    // R9 mode 0 countdown
    wr(3, 32'h003, "R9");
    rd(0, "R9");
    idle(26'h1, 0, "R9");
    for (int i = 0; i < 8; i++) idle(0, 1, "R9");

    // R7 freeze with enable low
    rd(0, "R7");
    wr(2, 32'h0, "R7");
    for (int i = 0; i < 6; i++) idle(26'h1, 1, "R7");
    wr(2, 32'h1, "R7");
    for (int i = 0; i < 6; i++) idle(0, 1, "R8");

    // R10 mode 1 waits for an event
    wr(3, 32'h102, "R10");
    rd(0, "R10");
    for (int i = 0; i < 6; i++) idle(0, 1, "R10");
    idle(26'h1, 0, "R10");
    for (int i = 0; i < 5; i++) idle(0, 1, "R10");

    // R11 zero holdoff, both modes
    wr(3, 32'h100, "R11");
    rd(0, "R11");
    idle(26'h1, 0, "R11");
    idle(0, 0, "R11");
    wr(3, 32'h000, "R11");
    rd(0, "R11");
    idle(26'h1, 0, "R11");
    idle(0, 0, "R11");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic        s, w;
      logic [1:0]  a;
      logic [31:0] d;
      logic [25:0] e;
      logic        t;
      s = ($urandom % 4) == 0;
      w = $urandom % 2;
      a = 2'($urandom % 4);
      d = $urandom;
      if (a == 2'd3 && ($urandom % 4) != 0) d = d & 32'h107;
      if (a == 2'd2 && ($urandom % 3) != 0) d = d | 32'h1;
      e = (($urandom % 6) == 0) ? 26'(32'd1 << ($urandom % 26)) : 26'd0;
      t = ($urandom % 4) == 0;
      step(s, w, a, d, e, t, "R6 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule